// File: doc/BRIEF.md
# Memory-mapped interrupt controller with edge latches

The block gathers 64 interrupt sources into two 32-bit banks and drives two processor interrupt lines, a normal one and a fast one. Each source is fixed at build time as either level-sensitive (the synchronised input passes straight through) or edge-sensitive (a rising edge is caught in a latch that software releases explicitly). Software can also force any source active with a trigger bit. It can gate each source with an enable and steer it to either output.

Software talks to the block over a plain 32-bit register port: a write strobe, an address, write data and a combinational read-data return. Enables and triggers each have a write-1-to-set register and a separate write-1-to-clear register, so single bits change without a read-modify-write. To find the pending source, an interrupt handler reads the low-bank normal status word, then the high-bank one, and takes the lowest set bit.

Top module: `irqc_top`

## Requirements
- R1: After reset, all enable, trigger, select and edge latch bits are 0, and both irq_o and fiq_o are low.
- R2: A write to ENA_SET (0x20 low, 0x24 high) sets every enable bit written as 1. A write to ENA_CLR (0x28/0x2C) clears every enable bit written as 1. Bits written as 0 do not change. ENA_SET reads back the enables and ENA_CLR reads 0.
- R3: TRG_SET (0x30/0x34) and TRG_CLR (0x38/0x3C) set and clear the trigger bits in the same way as R2. A set trigger bit makes its source active whatever its input is. TRG_SET reads back the triggers and TRG_CLR reads 0.
- R4: Select bits are at 0x18/0x1C and can be read and written. An enabled active source whose select bit is 0 appears in IRQ_ST (0x00/0x04) and drives irq_o. One whose select bit is 1 appears in FIQ_ST (0x08/0x0C) and drives fiq_o instead.
- R5: On an edge source, a rising input edge sets the latch bit. The bit reads in EDGE_ST (0x60/0x64) and stays set after the input falls, until a 1 is written to that bit of EDGE_CLR (0x58/0x5C).
- R6: A level source (sense bit 1) follows its synchronised input in RAW_ST. Writing its bit in EDGE_CLR has no effect, and its EDGE_ST bit stays 0.
- R7: If a new rising edge and an EDGE_CLR write of the same bit take effect on the same clock edge, the latch stays set.
- R8: Source n is bit n%32 of bank n/32. For each function, the high-bank register is at the low-bank address plus 4.
- R9: RAW_ST (0x10/0x14) shows (input path OR trigger) for every source, regardless of enable and select. A source that is not enabled sets no status bit and drives no output.
- R10: SENSE (0x40/0x44) returns the build-time level mask (default: sources 4..7 and 36..39 are level, 0xF0 in each bank), and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| src_i | input | 64 | Raw interrupt source inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The edge detector and the edge-clear write can act on the same latch bit in one clock. The bench first sets the latch of an edge source and lets the input settle low. It then raises the input again and times an EDGE_CLR write so that the strobe is active on exactly the clock edge where the new rising edge is registered. The test passes only if EDGE_ST still shows the bit afterwards: a design in which the clear wins would silently drop the second event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned NBANK  = 2;
  localparam int unsigned NSRC   = BANK_W * NBANK;

  // register function code = addr[6:3]; addr[2] picks the bank
  typedef enum logic [3:0] {
    F_IRQ_ST   = 4'd0,
    F_FIQ_ST   = 4'd1,
    F_RAW_ST   = 4'd2,
    F_SEL      = 4'd3,
    F_ENA_SET  = 4'd4,
    F_ENA_CLR  = 4'd5,
    F_TRG_SET  = 4'd6,
    F_TRG_CLR  = 4'd7,
    F_SENSE    = 4'd8,
    F_DUAL     = 4'd9,
    F_EVENT    = 4'd10,
    F_EDGE_CLR = 4'd11,
    F_EDGE_ST  = 4'd12
  } func_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            valid_i,
  input  logic [3:0]      func_i,
  input  logic            bank_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] trig_o,
  output logic [NSRC-1:0] sel_o,
  output logic [NSRC-1:0] eclr_o
);
  logic wr;
  assign wr = wr_en_i & valid_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = wr && (bank_i == b[0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[b*BANK_W +: BANK_W]   <= '0;
        trig_o[b*BANK_W +: BANK_W] <= '0;
        sel_o[b*BANK_W +: BANK_W]  <= '0;
      end else if (hit) begin
        case (func_i)
          F_ENA_SET: en_o[b*BANK_W +: BANK_W]   <= en_o[b*BANK_W +: BANK_W] | wdata_i;
          F_ENA_CLR: en_o[b*BANK_W +: BANK_W]   <= en_o[b*BANK_W +: BANK_W] & ~wdata_i;
          F_TRG_SET: trig_o[b*BANK_W +: BANK_W] <= trig_o[b*BANK_W +: BANK_W] | wdata_i;
          F_TRG_CLR: trig_o[b*BANK_W +: BANK_W] <= trig_o[b*BANK_W +: BANK_W] & ~wdata_i;
          F_SEL:     sel_o[b*BANK_W +: BANK_W]  <= wdata_i;
          default: ;
        endcase
      end
    end

    assign eclr_o[b*BANK_W +: BANK_W] =
      (hit && func_i == F_EDGE_CLR) ? wdata_i : '0;
  end
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge
  import irqc_pkg::*;
#(
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [NSRC-1:0] LEVEL_MASK  = 64'h0000_00F0_0000_00F0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] eclr_i,
  output logic [NSRC-1:0] src_o,
  output logic [NSRC-1:0] latch_o,
  output logic [NSRC-1:0] rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], src_i[i]};
    end

    if (LEVEL_MASK[i]) begin : g_level
      assign src_o[i]   = sync_q[LAST];
      assign latch_o[i] = 1'b0;
      assign rise_o[i]  = 1'b0;
    end else begin : g_edge
      logic prev_q, lat_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          lat_q  <= 1'b0;
        end else begin
          prev_q <= sync_q[LAST];
          // a fresh edge wins over a clear in the same cycle
          lat_q  <= (lat_q & ~eclr_i[i]) | rise_o[i];
        end
      end
      assign rise_o[i]  = sync_q[LAST] & ~prev_q;
      assign src_o[i]   = lat_q;
      assign latch_o[i] = lat_q;
    end
  end
endmodule

// File: rtl/irqc_read.sv
module irqc_read
  import irqc_pkg::*;
#(
  parameter logic [NSRC-1:0] LEVEL_MASK = 64'h0000_00F0_0000_00F0
) (
  input  logic              valid_i,
  input  logic [3:0]        func_i,
  input  logic              bank_i,
  input  logic [NSRC-1:0]   src_i,
  input  logic [NSRC-1:0]   latch_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [NSRC-1:0]   trig_i,
  input  logic [NSRC-1:0]   sel_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [NSRC-1:0] raw, irq_st, fiq_st;
  assign raw    = src_i | trig_i;
  assign irq_st = raw & en_i & ~sel_i;
  assign fiq_st = raw & en_i & sel_i;
  assign irq_o  = |irq_st;
  assign fiq_o  = |fiq_st;

  always_comb begin
    rdata_o = '0;
    if (valid_i) begin
      case (func_i)
        F_IRQ_ST:  rdata_o = irq_st[bank_i*BANK_W +: BANK_W];
        F_FIQ_ST:  rdata_o = fiq_st[bank_i*BANK_W +: BANK_W];
        F_RAW_ST:  rdata_o = raw[bank_i*BANK_W +: BANK_W];
        F_SEL:     rdata_o = sel_i[bank_i*BANK_W +: BANK_W];
        F_ENA_SET: rdata_o = en_i[bank_i*BANK_W +: BANK_W];
        F_TRG_SET: rdata_o = trig_i[bank_i*BANK_W +: BANK_W];
        F_SENSE:   rdata_o = LEVEL_MASK[bank_i*BANK_W +: BANK_W];
        F_EDGE_ST: rdata_o = latch_i[bank_i*BANK_W +: BANK_W];
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned     ADDR_W      = 8,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [NSRC-1:0] LEVEL_MASK  = 64'h0000_00F0_0000_00F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o,
  output logic              fiq_o
);
  logic            valid, bank;
  logic [3:0]      func;
  logic [NSRC-1:0] en_q, trig_q, sel_q, eclr_w, srcv_w, latch_q, rise_w;

  assign valid = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:7] == '0);
  assign bank  = addr_i[2];
  assign func  = addr_i[6:3];

  irqc_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i,
    .valid_i (valid), .func_i (func), .bank_i (bank), .wdata_i,
    .en_o (en_q), .trig_o (trig_q), .sel_o (sel_q), .eclr_o (eclr_w)
  );

  irqc_edge #(.SYNC_STAGES(SYNC_STAGES), .LEVEL_MASK(LEVEL_MASK)) u_edge (
    .clk_i, .rst_ni, .src_i, .eclr_i (eclr_w),
    .src_o (srcv_w), .latch_o (latch_q), .rise_o (rise_w)
  );

  irqc_read #(.LEVEL_MASK(LEVEL_MASK)) u_read (
    .valid_i (valid), .func_i (func), .bank_i (bank),
    .src_i (srcv_w), .latch_i (latch_q), .en_i (en_q), .trig_i (trig_q),
    .sel_i (sel_q), .rdata_o, .irq_o, .fiq_o
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter logic [NSRC-1:0] LEVEL_MASK = 64'h0000_00F0_0000_00F0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [7:0]      addr_i,
  input logic [31:0]     wdata_i,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] trig_q,
  input logic [NSRC-1:0] sel_q,
  input logic [NSRC-1:0] latch_q,
  input logic [NSRC-1:0] rise_w,
  input logic            irq_o,
  input logic            fiq_o
);
  AST_ENA_SET_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 8'h20) |=> ((en_q[31:0] & $past(wdata_i)) == $past(wdata_i))); // R2

  AST_ENA_CLR_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 8'h28) |=> ((en_q[31:0] & $past(wdata_i)) == 32'h0)); // R2

  AST_TRIG_DRIVES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(trig_q & en_q & ~sel_q)) |-> irq_o); // R3

  AST_TRIG_DRIVES_FIQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(trig_q & en_q & sel_q)) |-> fiq_o); // R4

  AST_EDGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_w) |=> ((latch_q & $past(rise_w)) == $past(rise_w))); // R7

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_q & LEVEL_MASK) == '0)); // R6
endmodule

bind irqc_top irqc_chk #(.LEVEL_MASK(LEVEL_MASK)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
  .en_q, .trig_q, .sel_q, .latch_q, .rise_w, .irq_o, .fiq_o
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic        irq, fiq;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  irqc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(req, rdata, exp);
  endtask

  task automatic pins_chk(input string req, input logic ei, input logic ef);
    @(negedge clk);
    check({req, " irq"}, {31'h0, irq}, {31'h0, ei});
    check({req, " fiq"}, {31'h0, fiq}, {31'h0, ef});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 ena", 8'h20, 0);
    rd_chk("R1 trg", 8'h34, 0);
    rd_chk("R1 sel", 8'h18, 0);
    rd_chk("R1 edge lo", 8'h60, 0);
    rd_chk("R1 edge hi", 8'h64, 0);
    pins_chk("R1", 0, 0);
  endtask

  task automatic t_enable;
    wr(8'h20, 32'h5);
    rd_chk("R2 set", 8'h20, 32'h5);
    wr(8'h20, 32'h2);
    rd_chk("R2 zeros keep", 8'h20, 32'h7);
    wr(8'h28, 32'h1);
    rd_chk("R2 clr", 8'h20, 32'h6);
    rd_chk("R2 clr reads 0", 8'h28, 0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk("R2 clr all", 8'h20, 0);
  endtask

  task automatic t_trigger;
    wr(8'h30, 32'h1);
    wr(8'h20, 32'h1);
    rd_chk("R3 trg read", 8'h30, 32'h1);
    rd_chk("R3 irq st", 8'h00, 32'h1);
    pins_chk("R3", 1, 0);
    rd_chk("R3 trg clr reads 0", 8'h38, 0);
    wr(8'h38, 32'h1);
    rd_chk("R3 trg cleared", 8'h30, 0);
    pins_chk("R3 off", 0, 0);
    wr(8'h28, 32'hFFFF_FFFF);
  endtask

  task automatic t_select;
    wr(8'h30, 32'h2);
    wr(8'h20, 32'h2);
    wr(8'h18, 32'h2);
    rd_chk("R4 sel read", 8'h18, 32'h2);
    rd_chk("R4 fiq st", 8'h08, 32'h2);
    rd_chk("R4 irq st", 8'h00, 0);
    pins_chk("R4 fast", 0, 1);
    wr(8'h18, 32'h0);
    rd_chk("R4 irq st back", 8'h00, 32'h2);
    pins_chk("R4 normal", 1, 0);
    wr(8'h38, 32'h2);
    wr(8'h28, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge;
    @(negedge clk); src[2] = 1'b1;
    idle(2);
    src[2] = 1'b0;
    idle(5);
    rd_chk("R5 latch held", 8'h60, 32'h4);
    rd_chk("R5 raw", 8'h10, 32'h4);
    wr(8'h58, 32'h4);
    rd_chk("R5 cleared", 8'h60, 0);
    rd_chk("R5 raw cleared", 8'h10, 0);
  endtask

  task automatic t_level;
    @(negedge clk); src[4] = 1'b1;
    idle(4);
    rd_chk("R6 level raw", 8'h10, 32'h10);
    wr(8'h58, 32'h10);
    rd_chk("R6 clr no effect", 8'h10, 32'h10);
    rd_chk("R6 no latch", 8'h60, 0);
    @(negedge clk); src[4] = 1'b0;
    idle(4);
    rd_chk("R6 level low", 8'h10, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk); src[3] = 1'b1;
    idle(2); src[3] = 1'b0;
    idle(5);
    rd_chk("R7 pre latch", 8'h60, 32'h8);
    @(negedge clk); src[3] = 1'b1;   // sync stage 1 next edge
    @(negedge clk);                  // stage 2 next edge, rise after it
    wr(8'h58, 32'h8);                // strobe lands on the edge that registers the rise
    rd_chk("R7 edge beats clear", 8'h60, 32'h8);
    @(negedge clk); src[3] = 1'b0;
    idle(4);
    wr(8'h58, 32'h8);
    rd_chk("R7 later clear", 8'h60, 0);
  endtask

  task automatic t_bank;
    wr(8'h24, 32'h100);
    rd_chk("R8 hi ena", 8'h24, 32'h100);
    rd_chk("R8 lo ena untouched", 8'h20, 0);
    @(negedge clk); src[40] = 1'b1;
    idle(4);
    rd_chk("R8 hi irq st", 8'h04, 32'h100);
    rd_chk("R8 lo irq st", 8'h00, 0);
    pins_chk("R8", 1, 0);
    @(negedge clk); src[40] = 1'b0;
    wr(8'h5C, 32'h100);
    rd_chk("R8 hi edge cleared", 8'h64, 0);
    wr(8'h2C, 32'hFFFF_FFFF);
    pins_chk("R8 idle", 0, 0);
  endtask

  task automatic t_raw;
    wr(8'h30, 32'h8);
    rd_chk("R9 raw w/o enable", 8'h10, 32'h8);
    rd_chk("R9 no irq st", 8'h00, 0);
    rd_chk("R9 no fiq st", 8'h08, 0);
    pins_chk("R9", 0, 0);
    wr(8'h38, 32'h8);
  endtask

  task automatic t_sense;
    rd_chk("R10 sense lo", 8'h40, 32'hF0);
    rd_chk("R10 sense hi", 8'h44, 32'hF0);
    wr(8'h40, 32'h0);
    rd_chk("R10 sense ro", 8'h40, 32'hF0);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1'b1;
        t_reset;
        t_enable;
        t_trigger;
        t_select;
        t_edge;
        t_level;
        t_same_cycle;
        t_bank;
        t_raw;
        t_sense;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule